// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Control

This block is a watchdog that counts clock cycles and raises a one-cycle reset request when the selected time-out passes without a refresh. Its behaviour is set by an 8-bit control byte. Three bits pick the time-out, and one bit decides whether counting goes on while the core is halted. A stop-inhibit bit is stored and read back for the core's stop logic, which lies outside this block. The three low bits are reserved.

Software can change the control byte only during the very first instruction after reset. The core marks that instruction with a qualifier input. When the qualifier drops for the first time, the control register is locked until the next reset. The periods are powers of two of the oscillator clock. The longest setting is four times the next one down, not twice. A shift parameter divides every period by the same power of two, so short runs can still exercise all settings.

Top module: `watchdog_lockctl`

## Requirements
- R1: The control byte can be written only while `firstInstr` is high and it has not yet fallen since reset. In that case `ctrlByte[7:3]` takes `cfgWrData[7:3]` at the clock edge when `cfgWrEn` is high. All other writes are ignored until the next reset.
- R2: The select field is `ctrlByte[6:4]`. Values 1 to 6 give a period of 2^(15+sel) cycles and value 7 gives 2^23 cycles. Every period is divided by 2^SCALE_SHIFT.
- R3: Reset loads the control byte with 0x98: select 001, halt-run bit 7 set, stop-inhibit bit 3 set.
- R4: If `halted` is high and bit 7 is 0, the count holds and no time-out is raised. If bit 7 is 1, counting continues while halted.
- R5: Bits 2 to 0 of `ctrlByte` always read 0, whatever value is written.
- R6: A `kick` at a clock edge clears the count. The next time-out is seen exactly one period of edges after that edge, unless another kick or a select change comes first.
- R7: `timeoutReset` is high for exactly one cycle. Without kicks, it repeats once every period.
- R8: While the select is 000, the count is held at zero and `timeoutReset` stays low.
- R9: An accepted write that changes the select value clears the count. The new period then starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control byte write strobe |
| cfgWrData | input | 8 | Control byte write data |
| firstInstr | input | 1 | High while the first instruction after reset is executing |
| kick | input | 1 | Refresh strobe; clears the count |
| halted | input | 1 | Core is in halt mode |
| ctrlByte | output | 8 | Current control byte, reserved bits zero |
| timeoutReset | output | 1 | One-cycle reset request on time-out |

## Verification
The assertions assume that `firstInstr` behaves like a qualifier that goes high once after reset and then low. A pulse that comes later must have no effect. They also assume `SCALE_SHIFT` is small enough to leave every period at two cycles or more, so a time-out pulse cannot fire on back-to-back edges. The stimulus raises `firstInstr` only in the first cycles after each reset, plus some deliberate late pulses to test the lock. It drives `kick`, `halted` and `cfgWrEn` at random rates and picks short selects. This lets many time-outs and halt freezes happen within each reset interval.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int HALT_RUN_BIT = 7;
  localparam int SEL_MSB      = 6;
  localparam int SEL_LSB      = 4;
  localparam int STOP_INH_BIT = 3;
  localparam int BASE_EXP     = 15;
  localparam int TOP_EXP      = 23;
  // upper five bits only: {haltRun, sel[2:0], stopInhibit}
  localparam logic [4:0] CTRL_HI_RST = 5'b1_001_1;

  typedef struct packed {
    logic clear;
    logic advance;
  } cnt_cmd_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  input  logic       firstInstr,
  input  logic       kick,
  input  logic       halted,
  output logic [4:0] ctrlHi,
  output logic [2:0] sel,
  output cnt_cmd_t   cmd
);
  logic firstQ;
  logic lockedQ;
  logic wrAccept;
  logic selChange;
  logic haltRun;

  assign wrAccept  = cfgWrEn && firstInstr && !lockedQ;
  assign sel       = ctrlHi[SEL_MSB-3:SEL_LSB-3];
  assign haltRun   = ctrlHi[HALT_RUN_BIT-3];
  assign selChange = wrAccept && (cfgWrData[SEL_MSB:SEL_LSB] != sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      firstQ  <= 1'b0;
      lockedQ <= 1'b0;
    end else begin
      firstQ <= firstInstr;
      if (firstQ && !firstInstr) lockedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrlHi <= CTRL_HI_RST;
    else if (wrAccept) ctrlHi <= cfgWrData[7:3];
  end

  always_comb begin
    cmd.clear   = kick || selChange || (sel == 3'd0);
    cmd.advance = !halted || haltRun;
  end

  // R1
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockedQ |=> $stable(ctrlHi));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int SCALE_SHIFT = 0,
  localparam int CW = TOP_EXP - SCALE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sel,
  input  cnt_cmd_t      cmd,
  output logic [CW-1:0] cntVal,
  output logic          timeoutReset
);
  logic [CW-1:0] limitTab [8];
  logic [CW-1:0] limit;

  assign limitTab[0] = '0;
  for (genvar g = 1; g < 8; g++) begin : g_lim
    localparam int EXPO = (g == 7) ? TOP_EXP : BASE_EXP + g;
    assign limitTab[g] = CW'((64'd1 << (EXPO - SCALE_SHIFT)) - 64'd1);
  end

  assign limit = limitTab[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntVal       <= '0;
      timeoutReset <= 1'b0;
    end else if (cmd.clear) begin
      cntVal       <= '0;
      timeoutReset <= 1'b0;
    end else if (cmd.advance) begin
      if (cntVal == limit) begin
        cntVal       <= '0;
        timeoutReset <= 1'b1;
      end else begin
        cntVal       <= cntVal + CW'(1);
        timeoutReset <= 1'b0;
      end
    end else begin
      timeoutReset <= 1'b0;
    end
  end

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutReset |=> !timeoutReset);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |=> (cntVal == '0 && !timeoutReset));
endmodule

// File: rtl/watchdog_lockctl.sv
module watchdog_lockctl
  import wdog_pkg::*;
#(
  parameter int SCALE_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  input  logic       firstInstr,
  input  logic       kick,
  input  logic       halted,
  output logic [7:0] ctrlByte,
  output logic       timeoutReset
);
  localparam int CW = TOP_EXP - SCALE_SHIFT;

  logic [4:0]    ctrlHi;
  logic [2:0]    sel;
  cnt_cmd_t      cmd;
  logic [CW-1:0] cntVal;

  wdog_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .firstInstr(firstInstr),
    .kick      (kick),
    .halted    (halted),
    .ctrlHi    (ctrlHi),
    .sel       (sel),
    .cmd       (cmd)
  );

  wdog_count #(.SCALE_SHIFT(SCALE_SHIFT)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .cmd         (cmd),
    .cntVal      (cntVal),
    .timeoutReset(timeoutReset)
  );

  assign ctrlByte = {ctrlHi, 3'b000};

  // R6
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cntVal == '0 && !timeoutReset));

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ctrlByte[HALT_RUN_BIT] && !kick && !(cfgWrEn && firstInstr))
      |=> ($stable(cntVal) && !timeoutReset));
endmodule

// File: tb/sim_watchdog_lockctl.sv
module sim_watchdog_lockctl;
  localparam int S = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic firstInstr = 1'b0;
  logic kick = 1'b0;
  logic halted = 1'b0;
  logic [7:0] ctrlByte;
  logic timeoutReset;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // reference state
  logic [4:0] mHi;
  bit mLocked, mFirstQ, mTmo;
  int mCnt;

  always #2.5 clk = ~clk;

  watchdog_lockctl #(.SCALE_SHIFT(S)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .firstInstr(firstInstr), .kick(kick), .halted(halted),
    .ctrlByte(ctrlByte), .timeoutReset(timeoutReset)
  );

  function automatic int periodOf(input logic [2:0] s);
    if (s == 3'd7) return 1 << (23 - S);
    return 1 << (15 + int'(s) - S);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void mReset();
    mHi = 5'b1_001_1; mLocked = 0; mFirstQ = 0; mTmo = 0; mCnt = 0;
  endfunction

  function automatic void mStep();
    logic [4:0] nHi;
    nHi = mHi;
    if (cfgWrEn && firstInstr && !mLocked) nHi = cfgWrData[7:3];
    if (kick || (nHi[3:1] != mHi[3:1]) || mHi[3:1] == 3'd0) begin
      mCnt = 0; mTmo = 0;
    end else if (!halted || mHi[4]) begin
      if (mCnt == periodOf(mHi[3:1]) - 1) begin mCnt = 0; mTmo = 1; end
      else begin mCnt++; mTmo = 0; end
    end else mTmo = 0;
    if (mFirstQ && !firstInstr) mLocked = 1;
    mFirstQ = firstInstr;
    mHi = nHi;
  endfunction

  task automatic cycle();
    @(posedge clk);
    mStep();
    @(negedge clk);
    chk("R6/R7 model timeout", 32'(timeoutReset), 32'(mTmo));
    chk("R1/R5 model ctrl", 32'(ctrlByte), {24'd0, mHi, 3'b000});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; cfgWrEn = 0; firstInstr = 0; kick = 0; halted = 0; cfgWrData = '0;
    mReset();
    repeat (2) @(negedge clk);
    chk("R3 reset ctrl", 32'(ctrlByte), 32'h98);
    chk("R3 reset timeout", 32'(timeoutReset), 32'd0);
    rst_n = 1;
  endtask

  // write in the first-instruction window together with a kick, then close it
  task automatic firstWrite(input logic [7:0] d);
    cfgWrEn = 1; cfgWrData = d; firstInstr = 1; kick = 1;
    cycle();
    cfgWrEn = 0; firstInstr = 0; kick = 0;
  endtask

  initial begin
    int k, firstHit, secondHit;
    void'($urandom(32'd2718));
    doReset();

    // R1 / R5: accepted write in the window, reserved bits forced to zero
    firstWrite(8'hFF);
    chk("R5 reserved bits", 32'(ctrlByte), 32'hF8);
    cycle();
    // R1: late first-instruction pulse with a write is ignored
    cfgWrEn = 1; cfgWrData = 8'h00; firstInstr = 1;
    cycle();
    cfgWrEn = 0; firstInstr = 0;
    chk("R1 locked write ignored", 32'(ctrlByte), 32'hF8);

    // R1: write without qualifier ignored even before the window closes
    doReset();
    cfgWrEn = 1; cfgWrData = 8'h20;
    cycle();
    cfgWrEn = 0;
    chk("R1 unqualified write", 32'(ctrlByte), 32'h98);

    // R2 / R7 / R9: every select, first and second pulse positions
    for (int s = 1; s < 8; s++) begin
      doReset();
      firstWrite({1'b1, 3'(s), 1'b1, 3'b000});
      firstHit = -1; secondHit = -1;
      for (k = 1; k <= 2 * periodOf(3'(s)) + 2; k++) begin
        cycle();
        if (timeoutReset) begin
          if (firstHit < 0) firstHit = k; else if (secondHit < 0) secondHit = k;
        end
      end
      chk($sformatf("R2 first timeout sel %0d", s), 32'(firstHit), 32'(periodOf(3'(s))));
      chk($sformatf("R7 repeat timeout sel %0d", s), 32'(secondHit), 32'(2 * periodOf(3'(s))));
    end

    // R9: select change alone restarts the count (no kick)
    doReset();
    repeat (10) cycle();
    cfgWrEn = 1; cfgWrData = 8'hA8; firstInstr = 1;
    cycle();
    cfgWrEn = 0; firstInstr = 0;
    firstHit = -1;
    for (k = 1; k <= 40; k++) begin cycle(); if (timeoutReset && firstHit < 0) firstHit = k; end
    chk("R9 select change clears", 32'(firstHit), 32'(periodOf(3'd2)));

    // R8: select 000 never times out
    doReset();
    firstWrite(8'h88);
    firstHit = 0;
    for (k = 0; k < 3000; k++) begin cycle(); if (timeoutReset) firstHit++; end
    chk("R8 disabled no timeout", 32'(firstHit), 32'd0);

    // R4: halt with bit 7 clear freezes, resume finishes remaining count
    doReset();
    firstWrite(8'h18);
    repeat (5) cycle();
    halted = 1;
    firstHit = 0;
    for (k = 0; k < 100; k++) begin cycle(); if (timeoutReset) firstHit++; end
    chk("R4 frozen in halt", 32'(firstHit), 32'd0);
    halted = 0;
    firstHit = -1;
    for (k = 1; k <= 20; k++) begin cycle(); if (timeoutReset && firstHit < 0) firstHit = k; end
    chk("R4 resume remainder", 32'(firstHit), 32'(periodOf(3'd1) - 5));

    // R4: bit 7 set keeps counting in halt
    doReset();
    firstWrite(8'h98);
    halted = 1;
    firstHit = -1;
    for (k = 1; k <= 20; k++) begin cycle(); if (timeoutReset && firstHit < 0) firstHit = k; end
    halted = 0;
    chk("R4 runs in halt", 32'(firstHit), 32'(periodOf(3'd1)));

    // R6: kick just before expiry postpones the timeout
    doReset();
    firstWrite(8'h98);
    repeat (periodOf(3'd1) - 2) cycle();
    kick = 1; cycle(); kick = 0;
    firstHit = -1;
    for (k = 1; k <= 20; k++) begin cycle(); if (timeoutReset && firstHit < 0) firstHit = k; end
    chk("R6 kick postpones", 32'(firstHit), 32'(periodOf(3'd1)));

    // random phases checked cycle by cycle against the reference
    for (int ph = 0; ph < 6; ph++) begin
      doReset();
      firstWrite({1'($urandom), 3'($urandom % 5), 1'($urandom), 3'($urandom)});
      for (int c = 0; c < 1500; c++) begin
        kick       = ($urandom % 48) == 0;
        if (($urandom % 40) == 0) halted = ~halted;
        cfgWrEn    = ($urandom % 60) == 0;
        firstInstr = cfgWrEn && (($urandom % 2) == 0);
        cfgWrData  = {1'($urandom), 3'($urandom % 4), 1'($urandom), 3'($urandom)};
        cycle();
      end
      cfgWrEn = 0; firstInstr = 0; kick = 0; halted = 0;
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule